// File: doc/BRIEF.md
# Gated Counter/Timer with Auto-Reload

This block is one counter/timer channel built from two software-visible bytes, a low byte and a high byte. With `mode16` set, the two bytes form a single 16-bit up-counter that wraps from all ones to zero and raises an overflow flag. With `mode16` clear, only the low byte counts. The high byte then acts as a fixed reload value, which is copied into the low byte on each rollover.

The count source has two choices. One is an internal clock: either every system clock cycle, or the cycles on which an external prescaler strobe is high. The other is the falling edges of an external count pin, taken through a synchronizer. Counting is allowed by a software run bit. It can also be gated by an external pin, whose active level comes from a polarity bit. A sticky overflow flag drives a level interrupt request when the interrupt enable is set. Software loads either byte through a shared write-data bus and reads both bytes at all times.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset, `lo_q`, `hi_q`, `ovf_flag` and `irq` are all zero.
- R2: With `mode16`=1, `{hi_q,lo_q}` advances by one on each count tick, and the low byte carries into the high byte.
- R3: With `mode16`=1, a tick at 0xFFFF gives 0x0000 with no reload, and it sets `ovf_flag`.
- R4: With `mode16`=0, only `lo_q` counts. A tick at `lo_q`=0xFF loads `lo_q` from `hi_q` and sets `ovf_flag` in the same cycle.
- R5: With `mode16`=0, counting and reloads never change `hi_q`; only a write to it does.
- R6: Starting the timer does not load `lo_q`. The first period counts on from whatever value was last written.
- R7: A tick is counted only when `run_en`=1 and either `gate_en`=0 or the gate input is active. When `gate_en`=0, the gate pin has no effect.
- R8: The gate input is active when (synchronized `gate_pin`) XOR `gate_pol` is 1. So `gate_pol`=0 selects active-high and `gate_pol`=1 selects active-low. The pin passes through a two-flop synchronizer.
- R9: With `src_sel`=1, the counter advances once for each falling edge of `count_pin`, detected after a two-flop synchronizer, and internal clocking is ignored. With `src_sel`=0, the internal source is used.
- R10: With `src_sel`=0, `clk_sel`=1 counts every clock cycle, and `clk_sel`=0 counts only the cycles where `prescale_tick`=1.
- R11: `ovf_flag` stays set until `clr_ovf` is pulsed. An overflow in the same cycle as `clr_ovf` leaves the flag set.
- R12: `irq` is 1 exactly while `ovf_flag`=1 and `irq_en`=1.
- R13: `wr_lo` and `wr_hi` load `wr_data` into their byte. A write cycle takes priority over counting, and the tick in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Software run bit |
| gate_en | input | 1 | Enables gating by the external gate pin |
| gate_pol | input | 1 | Gate polarity, XORed with the pin |
| gate_pin | input | 1 | External gate input (asynchronous) |
| src_sel | input | 1 | 0: internal clock source, 1: external count pin |
| clk_sel | input | 1 | 0: prescaler strobe, 1: system clock |
| prescale_tick | input | 1 | One-cycle strobe from the external prescaler |
| count_pin | input | 1 | External count input (asynchronous) |
| mode16 | input | 1 | 1: 16-bit counter, 0: 8-bit auto-reload |
| irq_en | input | 1 | Interrupt enable |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_data | input | BYTE_W | Write data |
| clr_ovf | input | 1 | Clears the overflow flag |
| lo_q | output | BYTE_W | Low byte |
| hi_q | output | BYTE_W | High byte / reload value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Every piece of internal state maps directly onto the outputs. A wrong count or reload shows in `lo_q`/`hi_q` on the very next clock. A wrong flag shows in `ovf_flag` and `irq` in that same cycle. A fault in either synchronizer or in the edge detector only shows after the two-flop delay. It appears as an extra count, a missing count, or a count during a gated-off window, so the bench waits a few cycles after each pin change before it compares totals. The tests run the counter across both wrap points and across several reload periods, so that an error in carry or reload order builds up into a visibly wrong byte.

// File: rtl/gated_reload_timer.sv
module gated_reload_timer #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              gate_en,
  input  logic              gate_pol,
  input  logic              gate_pin,
  input  logic              src_sel,
  input  logic              clk_sel,
  input  logic              prescale_tick,
  input  logic              count_pin,
  input  logic              mode16,
  input  logic              irq_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clr_ovf,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_flag,
  output logic              irq
);
  localparam int                MSB      = SYNC_STAGES - 1;
  localparam logic [BYTE_W-1:0] BYTE_MAX = '1;

  logic [SYNC_STAGES-1:0] cnt_sync, gate_sync;
  logic cnt_prev;
  logic pin_fall, gate_act, run_ok, int_tick, cnt_tick, wr_any;
  logic lo_full, hi_full, ovf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_sync  <= '1;
      cnt_prev  <= 1'b1;
      gate_sync <= '0;
    end else begin
      cnt_sync  <= {cnt_sync[SYNC_STAGES-2:0], count_pin};
      cnt_prev  <= cnt_sync[MSB];
      gate_sync <= {gate_sync[SYNC_STAGES-2:0], gate_pin};
    end
  end

  assign pin_fall = cnt_prev & ~cnt_sync[MSB];
  assign gate_act = gate_sync[MSB] ^ gate_pol;
  assign run_ok   = run_en & (~gate_en | gate_act);
  assign int_tick = clk_sel ? 1'b1 : prescale_tick;
  assign cnt_tick = run_ok & (src_sel ? pin_fall : int_tick);
  assign wr_any   = wr_lo | wr_hi;

  assign lo_full  = (lo_q == BYTE_MAX);
  assign hi_full  = (hi_q == BYTE_MAX);
  assign ovf_evt  = cnt_tick & ~wr_any & lo_full & (~mode16 | hi_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_any) begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_hi) hi_q <= wr_data;
    end else if (cnt_tick) begin
      if (!mode16 && lo_full) lo_q <= hi_q;
      else                    lo_q <= lo_q + 1'b1;
      if (mode16 && lo_full)  hi_q <= hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_evt) ovf_flag <= 1'b1;
    else if (clr_ovf) ovf_flag <= 1'b0;
  end

  assign irq = ovf_flag & irq_en;
endmodule

module timer_props #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              mode16,
  input logic              irq_en,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              clr_ovf,
  input logic              tick,
  input logic [BYTE_W-1:0] lo_q,
  input logic [BYTE_W-1:0] hi_q,
  input logic              ovf_flag,
  input logic              irq
);
  localparam logic [BYTE_W-1:0] ONES = '1;

  assert_wrap16_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && tick && !wr_lo && !wr_hi && lo_q == ONES && hi_q == ONES)
      |=> (lo_q == '0 && hi_q == '0 && ovf_flag));

  assert_reload8_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode16 && tick && !wr_lo && !wr_hi && lo_q == ONES)
      |=> (lo_q == $past(hi_q) && ovf_flag));

  assert_reload_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode16 && !wr_hi) |=> (hi_q == $past(hi_q)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  assert_irq_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && irq_en) |-> irq);
endmodule

bind gated_reload_timer timer_props #(.BYTE_W(BYTE_W)) u_props (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode16(mode16),
  .irq_en(irq_en), .wr_lo(wr_lo), .wr_hi(wr_hi), .clr_ovf(clr_ovf),
  .tick(cnt_tick), .lo_q(lo_q), .hi_q(hi_q), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/tb_gated_reload_timer.sv
module tb_gated_reload_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, gate_en = 0, gate_pol = 0, gate_pin = 0;
  logic src_sel = 0, clk_sel = 1, prescale_tick = 0, count_pin = 1;
  logic mode16 = 1, irq_en = 0, wr_lo = 0, wr_hi = 0, clr_ovf = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] lo_q, hi_q;
  logic ovf_flag, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gated_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_en(gate_en),
    .gate_pol(gate_pol), .gate_pin(gate_pin), .src_sel(src_sel),
    .clk_sel(clk_sel), .prescale_tick(prescale_tick), .count_pin(count_pin),
    .mode16(mode16), .irq_en(irq_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .clr_ovf(clr_ovf), .lo_q(lo_q), .hi_q(hi_q),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk); wr_lo = 1; wr_data = lo;
    @(negedge clk); wr_lo = 0; wr_hi = 1; wr_data = hi;
    @(negedge clk); wr_hi = 0;
  endtask

  task automatic run_cycles(input int n);
    @(negedge clk); run_en = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); run_en = 0;
  endtask

  task automatic clear_flag;
    @(negedge clk); clr_ovf = 1;
    @(negedge clk); clr_ovf = 0;
  endtask

  task automatic t_reset;
    chk("R1 lo", {8'h0, lo_q}, 16'h0);
    chk("R1 hi", {8'h0, hi_q}, 16'h0);
    chk("R1 flags", {14'h0, ovf_flag, irq}, 16'h0);
  endtask

  task automatic t_count16;
    mode16 = 1; load(8'hF0, 8'h12);
    run_cycles(20);
    chk("R2 carry", {hi_q, lo_q}, 16'h1304);
    chk("R2 no flag", {15'h0, ovf_flag}, 16'h0);
    load(8'hFE, 8'hFF);
    run_cycles(3);
    chk("R3 wrap", {hi_q, lo_q}, 16'h0001);
    chk("R3 flag", {15'h0, ovf_flag}, 16'h1);
  endtask

  task automatic t_irq_clear;
    chk("R12 irq off", {15'h0, irq}, 16'h0);
    @(negedge clk); irq_en = 1; #1;
    chk("R12 irq on", {15'h0, irq}, 16'h1);
    repeat (3) @(negedge clk);
    chk("R11 sticky", {15'h0, ovf_flag}, 16'h1);
    clear_flag;
    chk("R11 cleared", {15'h0, ovf_flag}, 16'h0);
    chk("R12 irq drops", {15'h0, irq}, 16'h0);
    load(8'hFF, 8'hFF);
    @(negedge clk); run_en = 1; clr_ovf = 1;
    @(negedge clk); run_en = 0; clr_ovf = 0;
    chk("R11 set wins", {15'h0, ovf_flag}, 16'h1);
    irq_en = 0; clear_flag;
  endtask

  task automatic t_reload8;
    mode16 = 0; load(8'hFE, 8'h80);
    run_cycles(3);
    chk("R4 reload", {8'h0, lo_q}, 16'h0081);
    chk("R4 flag", {15'h0, ovf_flag}, 16'h1);
    chk("R5 hi kept", {8'h0, hi_q}, 16'h0080);
    clear_flag;
    load(8'hFC, 8'hFC);
    run_cycles(10);
    chk("R4 periods", {8'h0, lo_q}, 16'h00FE);
    chk("R5 hi kept multi", {8'h0, hi_q}, 16'h00FC);
    clear_flag;
    load(8'h10, 8'hF0);
    run_cycles(2);
    chk("R6 no start load", {8'h0, lo_q}, 16'h0012);
  endtask

  task automatic gate_case(input logic pol, input logic pin, input logic [7:0] exp, input string req);
    gate_pol = pol; gate_pin = pin;
    repeat (4) @(negedge clk);
    load(8'h00, 8'h00);
    run_cycles(5);
    chk(req, {8'h0, lo_q}, {8'h0, exp});
  endtask

  task automatic t_gate;
    mode16 = 1; gate_en = 1;
    gate_case(0, 0, 8'd0, "R7 gated off high-active");
    gate_case(0, 1, 8'd5, "R8 active high");
    gate_case(1, 0, 8'd5, "R8 active low");
    gate_case(1, 1, 8'd0, "R8 inactive low-pol");
    gate_en = 0;
    gate_case(1, 1, 8'd5, "R7 gate disabled");
    gate_pol = 0; gate_pin = 0;
  endtask

  task automatic t_prescale;
    clk_sel = 0; load(8'h00, 8'h00);
    @(negedge clk); run_en = 1;
    for (int i = 0; i < 10; i++) begin
      prescale_tick = (i % 2 == 0);
      @(negedge clk);
    end
    run_en = 0; prescale_tick = 0;
    chk("R10 prescaled", {8'h0, lo_q}, 16'h0005);
    clk_sel = 1;
  endtask

  task automatic t_extpin;
    src_sel = 1; load(8'h00, 8'h00);
    @(negedge clk); run_en = 1;
    for (int i = 0; i < 3; i++) begin
      count_pin = 0; repeat (4) @(negedge clk);
      count_pin = 1; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    run_en = 0;
    chk("R9 falling edges", {8'h0, lo_q}, 16'h0003);
    src_sel = 0;
  endtask

  task automatic t_write_prio;
    load(8'h00, 8'h00);
    @(negedge clk); run_en = 1;
    repeat (3) @(negedge clk);
    wr_lo = 1; wr_data = 8'h40;
    @(negedge clk); wr_lo = 0; run_en = 0;
    chk("R13 write wins", {8'h0, lo_q}, 16'h0040);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_count16;
    t_irq_clear;
    t_reload8;
    t_gate;
    t_prescale;
    t_extpin;
    t_write_prio;
    finish_run;
  end
endmodule